// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers a parameterized set of level-sensitive interrupt request lines (64 by default) and presents the processor with one interrupt at a time. Each source has an 8-bit priority byte and a mask bit. A source takes part in arbitration only when its priority byte is nonzero. The block picks the single strongest source that is pending, enabled and unmasked. It drives that source's priority and a vector number to the processor, both from registers.

Software reaches the block through a 32-bit register port that decodes a 256-byte window. The port uses a single-cycle write strobe and a single-cycle read strobe. Through it, software can:
- read the pending bits and the force bits;
- split the 64-bit mask into an upper and a lower word and write each on its own;
- set one priority byte per source;
- read the current vector from an acknowledge location.

Writes that land anywhere other than a mask word or a priority byte change nothing. Each such write raises a one-cycle error pulse.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The pending bit of source n holds the value that `irq_in[n]` had at the previous clock edge. Offset 0x00 reads pending bits 63..32 and offset 0x04 reads bits 31..0. A write to either offset leaves the pending bits unchanged.
- R2: A source is active when (pending OR force) AND enabled AND NOT masked. A source is enabled exactly when its priority byte is nonzero. The force bits read at 0x10 (bits 63..32) and 0x14 (bits 31..0); they are zero after reset and no write changes them.
- R3: Among the active sources, the winner has the greatest priority byte. When two priority bytes are equal, the source with the higher index wins.
- R4: `cpu_level` is the winner's priority byte and `cpu_vector` is the winner's index plus 64. Both are registered. A change of pending, mask or priority state appears on them at the next clock edge. A change on `irq_in` therefore appears two edges later.
- R5: When no source is active, `cpu_level` is 0 and `cpu_vector` is 24.
- R6: A write to 0x08 loads mask bits 63..32 from `wdata`, and a write to 0x0C loads mask bits 31..0. Each write leaves the other half unchanged. A mask bit of 1 blocks its source.
- R7: The priority byte of source n sits at offset 0x40+n. A write there takes `wdata[7:0]`, and a read returns the byte zero-extended to 32 bits.
- R8: A read strobe at one edge gives `rdata` at the next edge. Offset 0xE0 returns the current `cpu_vector`, and unmapped offsets return 0. `rdata` is 0 in any cycle that follows an edge without a read strobe.
- R9: A write to any offset other than 0x08, 0x0C or 0x40..0x7F changes no state. It sets `bad_wr` high for exactly the cycle after that write.
- R10: While reset is applied, every mask bit is set, and pending, force and all priority bytes are cleared. In the same period `cpu_level` is 0, `cpu_vector` is 24, `rdata` is 0 and `bad_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level-sensitive interrupt request lines |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 8 | Byte offset inside the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| bad_wr | output | 1 | One-cycle pulse after a write to an unwritable offset |
| cpu_level | output | 8 | Priority byte of the winning source, 0 when idle |
| cpu_vector | output | 8 | Winning source index plus 64, or 24 when idle |

## Verification
Assertions check the following on every cycle:
- the arbitration winner is active and carries its claimed priority, and no other active source beats it by a greater priority or, at equal priority, by a higher index;
- a zero output level always comes with vector 24, and a nonzero level always comes with a vector in the source range;
- writing one mask half leaves the other half as it was;
- a write to the pending word, and a read-free cycle, behave as required.

Only the bench's scenarios can show the following:
- the exact two-edge latency from a request line to the outputs;
- that writes to priority bytes and mask halves land at the right sources;
- that a zero priority byte removes its source;
- that readback values, the acknowledge word and the spurious vector match what software expects.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // byte offsets decoded by the register port
  localparam int OFS_PEND_HI  = 'h00;
  localparam int OFS_PEND_LO  = 'h04;
  localparam int OFS_MASK_HI  = 'h08;
  localparam int OFS_MASK_LO  = 'h0C;
  localparam int OFS_FORCE_HI = 'h10;
  localparam int OFS_FORCE_LO = 'h14;
  localparam int OFS_LVL_BASE = 'h40;
  localparam int OFS_ACK      = 'hE0;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int LW   = 8,
  parameter int VW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic [VW-1:0]      vec_now,
  output logic [NSRC-1:0]    active,
  output logic [NSRC*LW-1:0] lvl_flat,
  output logic [DW-1:0]      rdata,
  output logic               bad_wr
);
  localparam int WW = 2 * DW;
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [WW-1:0]   pend_q;
  logic [WW-1:0]   mask_q;
  logic [WW-1:0]   force_q;
  logic [LW-1:0]   lvl_q [NSRC];
  logic [NSRC-1:0] en_v;

  logic            lvl_hit;
  logic [AW-1:0]   lvl_off;
  logic [IW-1:0]   lvl_idx;
  logic            mhi_hit;
  logic            mlo_hit;
  logic            wr_ok;
  logic [DW-1:0]   rd_mux;

  // address decode
  assign lvl_hit = ({1'b0, addr} >= (AW+1)'(OFS_LVL_BASE)) &&
                   ({1'b0, addr} <  (AW+1)'(OFS_LVL_BASE + NSRC));
  assign lvl_off = addr - AW'(OFS_LVL_BASE);
  assign lvl_idx = lvl_off[IW-1:0];
  assign mhi_hit = (addr == AW'(OFS_MASK_HI));
  assign mlo_hit = (addr == AW'(OFS_MASK_LO));
  assign wr_ok   = mhi_hit || mlo_hit || lvl_hit;

  // state registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      mask_q  <= '1;
      force_q <= '0;
      bad_wr  <= 1'b0;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else begin
      pend_q <= WW'(irq_in);
      if (wr_en && mhi_hit) mask_q[WW-1:DW] <= wdata;
      if (wr_en && mlo_hit) mask_q[DW-1:0]  <= wdata;
      if (wr_en && lvl_hit) lvl_q[lvl_idx]  <= wdata[LW-1:0];
      bad_wr <= wr_en && !wr_ok;
    end
  end

  // per-source enable and flattened level bus
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign en_v[i]                 = |lvl_q[i];
    assign lvl_flat[i*LW +: LW]    = lvl_q[i];
  end

  assign active = (pend_q[NSRC-1:0] | force_q[NSRC-1:0]) & en_v & ~mask_q[NSRC-1:0];

  // read mux
  always_comb begin
    rd_mux = '0;
    if (addr == AW'(OFS_PEND_HI))       rd_mux = pend_q[WW-1:DW];
    else if (addr == AW'(OFS_PEND_LO))  rd_mux = pend_q[DW-1:0];
    else if (mhi_hit)                   rd_mux = mask_q[WW-1:DW];
    else if (mlo_hit)                   rd_mux = mask_q[DW-1:0];
    else if (addr == AW'(OFS_FORCE_HI)) rd_mux = force_q[WW-1:DW];
    else if (addr == AW'(OFS_FORCE_LO)) rd_mux = force_q[DW-1:0];
    else if (addr == AW'(OFS_ACK))      rd_mux = DW'(vec_now);
    else if (lvl_hit)                   rd_mux = DW'(lvl_q[lvl_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  // R6: one mask half written, the other half kept
  a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mhi_hit) |=> (mask_q[DW-1:0] == $past(mask_q[DW-1:0])))
    else $error("a_r6_hi_keeps_lo");
  a_r6_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mlo_hit) |=> (mask_q[WW-1:DW] == $past(mask_q[WW-1:DW])))
    else $error("a_r6_lo_keeps_hi");
  // R9: a write to the pending word is flagged
  a_r9_pend_write_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_PEND_HI)) |=> bad_wr)
    else $error("a_r9_pend_write_flag");
  // R8: no read strobe gives zero read data
  a_r8_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0))
    else $error("a_r8_idle_rdata");
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree #(
  parameter int NSRC = 64,
  parameter int LW   = 8,
  parameter int IW   = 6
) (
  input  logic [NSRC-1:0]    active,
  input  logic [NSRC*LW-1:0] lvl_flat,
  output logic [LW-1:0]      win_lvl,
  output logic [IW-1:0]      win_idx
);
  localparam int DEPTH = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NP    = 1 << DEPTH;

  // heap-ordered nodes: root at 1, children of k at 2k and 2k+1
  logic [LW-1:0] nl [2*NP];
  logic [IW-1:0] ni [2*NP];

  assign nl[0] = '0;
  assign ni[0] = '0;

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < NSRC) begin : g_real
      assign nl[NP+i] = active[i] ? lvl_flat[i*LW +: LW] : '0;
    end else begin : g_pad
      assign nl[NP+i] = '0;
    end
    assign ni[NP+i] = IW'(i);
  end

  // right child holds higher indices, so it wins ties
  for (genvar k = 1; k < NP; k++) begin : g_node
    logic take_r;
    assign take_r = (nl[2*k+1] >= nl[2*k]);
    assign nl[k]  = take_r ? nl[2*k+1] : nl[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  assign win_lvl = nl[1];
  assign win_idx = ni[1];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC     = 64,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int LW       = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_IDLE = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            bad_wr,
  output logic [LW-1:0]   cpu_level,
  output logic [VW-1:0]   cpu_vector
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]    active;
  logic [NSRC*LW-1:0] lvl_flat;
  logic [LW-1:0]      win_lvl;
  logic [IW-1:0]      win_idx;

  irq_regs #(
    .NSRC(NSRC), .DW(DW), .AW(AW), .LW(LW), .VW(VW)
  ) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .vec_now(cpu_vector), .active(active), .lvl_flat(lvl_flat),
    .rdata(rdata), .bad_wr(bad_wr)
  );

  irq_arb_tree #(
    .NSRC(NSRC), .LW(LW), .IW(IW)
  ) u_arb (
    .active(active), .lvl_flat(lvl_flat),
    .win_lvl(win_lvl), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_level  <= '0;
      cpu_vector <= VW'(VEC_IDLE);
    end else begin
      cpu_level  <= win_lvl;
      cpu_vector <= (win_lvl == '0) ? VW'(VEC_IDLE) : VW'(VEC_BASE) + VW'(win_idx);
    end
  end

  // brute-force cross-check of the tree result
  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int j = 0; j < NSRC; j++) begin
      if (active[j] && ((lvl_flat[j*LW +: LW] > win_lvl) ||
          (lvl_flat[j*LW +: LW] == win_lvl && j > int'(win_idx))))
        beaten = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && win_lvl != '0) begin
      // R3: the winner is real and carries its claimed level
      a_r3_winner_real: assert (active[win_idx] && lvl_flat[win_idx*LW +: LW] == win_lvl)
        else $error("a_r3_winner_real");
    end
    if (!rst) begin
      // R3: no active source beats the winner on level or tie index
      a_r3_not_beaten: assert (!beaten) else $error("a_r3_not_beaten");
    end
  end

  // R5: idle level comes with the spurious vector
  a_r5_idle_vector: assert property (@(posedge clk) disable iff (rst)
    (cpu_level == '0) |-> (cpu_vector == VW'(VEC_IDLE)))
    else $error("a_r5_idle_vector");
  // R4: a live level comes with a vector inside the source range
  a_r4_vector_range: assert property (@(posedge clk) disable iff (rst)
    (cpu_level != '0) |-> (cpu_vector >= VW'(VEC_BASE) && cpu_vector < VW'(VEC_BASE + NSRC)))
    else $error("a_r4_vector_range");
  // R10: reset drives the idle outputs
  a_r10_reset_out: assert property (@(posedge clk)
    rst |=> (cpu_level == '0 && cpu_vector == VW'(VEC_IDLE) && !bad_wr && rdata == '0))
    else $error("a_r10_reset_out");
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bad_wr;
  logic [7:0]  cpu_level, cpu_vector;

  int total = 0, bad = 0, cyc = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .bad_wr(bad_wr),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  // ---------------- reference model ----------------
  logic [63:0] m_pend, m_mask;
  logic [7:0]  m_lvl [64];
  logic [7:0]  m_vec, m_lv;
  logic [31:0] m_rd;
  logic        m_bad;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int ia = int'(a);
    if (ia == 0)  return m_pend[63:32];
    if (ia == 4)  return m_pend[31:0];
    if (ia == 8)  return m_mask[63:32];
    if (ia == 12) return m_mask[31:0];
    if (ia == 'hE0) return {24'd0, m_vec};
    if (ia >= 64 && ia < 128) return {24'd0, m_lvl[ia-64]};
    return 32'd0;
  endfunction

  always @(posedge clk) begin : model
    int best, bidx, ia;
    if (rst) begin
      m_pend = '0; m_mask = '1; m_vec = 8'd24; m_lv = 8'd0; m_rd = '0; m_bad = 1'b0;
      for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
    end else begin
      best = 0; bidx = 0;
      for (int i = 0; i < 64; i++)
        if (m_pend[i] && m_lvl[i] != 0 && !m_mask[i] && int'(m_lvl[i]) >= best) begin
          best = int'(m_lvl[i]); bidx = i;
        end
      m_rd  = rd_en ? m_read(addr) : 32'd0;
      m_vec = (best == 0) ? 8'd24 : 8'(64 + bidx);
      m_lv  = 8'(best);
      ia = int'(addr);
      m_bad = wr_en && !(ia == 8 || ia == 12 || (ia >= 64 && ia < 128));
      m_pend = irq;
      if (wr_en && ia == 8)  m_mask[63:32] = wdata;
      if (wr_en && ia == 12) m_mask[31:0]  = wdata;
      if (wr_en && ia >= 64 && ia < 128) m_lvl[ia-64] = wdata[7:0];
    end
    started = 1;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R4 level vs model", 32'(cpu_level), 32'(m_lv));
    chk("R4 vector vs model", 32'(cpu_vector), 32'(m_vec));
    chk("R8 rdata vs model", rdata, m_rd);
    chk("R9 bad_wr vs model", 32'(bad_wr), 32'(m_bad));
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = 8'(a);
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    chk("R10 vector after reset", 32'(cpu_vector), 32'd24);
    chk("R10 level after reset", 32'(cpu_level), 32'd0);
    rd('h08, v); chk("R10 mask upper set", v, 32'hFFFF_FFFF);
    rd('h0C, v); chk("R10 mask lower set", v, 32'hFFFF_FFFF);
    rd('h40, v); chk("R10 level byte zero", v, 32'd0);
    rd('h10, v); chk("R2 force upper zero", v, 32'd0);

    // R3 tie to higher index, with R4 latency
    wr('h45, 32'd3); wr('h68, 32'd3);
    wr('h08, 32'd0); wr('h0C, 32'd0);
    @(negedge clk); irq[5] = 1'b1; irq[40] = 1'b1;
    @(negedge clk); chk("R4 one edge after irq still idle", 32'(cpu_vector), 32'd24);
    @(negedge clk); chk("R3 tie goes to index 40", 32'(cpu_vector), 32'd104);
    chk("R4 winner level", 32'(cpu_level), 32'd3);
    wr('h45, 32'd7); idle(1);
    chk("R3 greater level wins", 32'(cpu_vector), 32'd69);
    rd('hE0, v); chk("R8 acknowledge vector", v, 32'd69);

    // R2 zero level stays ignored
    @(negedge clk); irq = '0; irq[10] = 1'b1;
    idle(2); chk("R2 zero-level source ignored", 32'(cpu_vector), 32'd24);
    wr('h4A, 32'd1); idle(1);
    chk("R2 nonzero level enables", 32'(cpu_vector), 32'd74);
    wr('h4A, 32'd0); idle(1);
    chk("R2 level cleared disables", 32'(cpu_vector), 32'd24);

    // R6 mask halves independent
    @(negedge clk); irq = '0; irq[5] = 1'b1; irq[40] = 1'b1;
    wr('h0C, 32'h20); idle(1);
    chk("R6 low mask blocks source 5", 32'(cpu_vector), 32'd104);
    rd('h08, v); chk("R6 upper half unchanged", v, 32'd0);
    wr('h08, 32'hFFFF_FFFF); idle(1);
    chk("R5 all masked spurious vector", 32'(cpu_vector), 32'd24);
    chk("R5 all masked level zero", 32'(cpu_level), 32'd0);
    rd('h0C, v); chk("R6 lower half unchanged", v, 32'h20);

    // R1 pending readback and ignored writes
    @(negedge clk); irq = '0; irq[40] = 1'b1; irq[1] = 1'b1;
    idle(2);
    rd('h00, v); chk("R1 pending upper", v, 32'h100);
    rd('h04, v); chk("R1 pending lower", v, 32'h2);
    wr('h00, 32'hFFFF_FFFF); chk("R9 pending write flagged", 32'(bad_wr), 32'd1);
    rd('h00, v); chk("R1 pending write ignored", v, 32'h100);
    wr('h14, 32'hFFFF_FFFF); chk("R9 force write flagged", 32'(bad_wr), 32'd1);
    rd('h14, v); chk("R2 force unchanged by write", v, 32'd0);
    rd('h20, v); chk("R8 unmapped read zero", v, 32'd0);

    // R7 level byte from low 8 bits
    wr('h45, 32'h1FF); rd('h45, v); chk("R7 level low byte", v, 32'hFF);

    // mixed random phase, compared every cycle against the model
    wr('h08, 32'd0); wr('h0C, 32'd0);
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin @(negedge clk); irq = {$urandom, $urandom}; end
        1: wr(64 + int'($urandom_range(0, 63)), 32'($urandom_range(0, 3)));
        2: wr(($urandom_range(0, 1) == 0) ? 'h08 : 'h0C, $urandom & $urandom);
        3: rd(int'($urandom_range(0, 255)), v);
        default: wr(int'($urandom_range(0, 63)) & 'h3B, $urandom);
      endcase
    end
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule